// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor

This block is a small 32-bit processor that retires one instruction per clock. On each rising edge it commits the result of the instruction addressed by the program counter. That result is a register write, a data-memory write, a new program counter, or a mix of these. The core holds its own instruction store and data store as internal word arrays. It also holds a 32-entry register file and a two-level decoder. In that decoder, the opcode selects an operation class, and for register-register instructions the function field picks the exact ALU operation.

The supported subset has two kinds of operation:
- Register-register arithmetic and logic: add, subtract, and, or, nor, and signed set-less-than.
- Word load, word store, branch-if-equal, and an absolute jump within the current 256 MB region.

A load port fills either store while reset is held. A registered peek port reads back any data-memory word, so a program's results can be inspected at the boundary.

Top module: `sc_cpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_o` becomes 0 at that edge. No register-file or data-memory write from program execution happens during that cycle.
- R2: An instruction with opcode `000000` writes `f(rs, rt)` into register `instr[15:11]`. Here rs is `instr[25:21]` and rt is `instr[20:16]`. The function field `instr[5:0]` selects f: `100000` add, `100010` subtract (rs−rt), `100100` and, `100101` or, `100111` nor. All arithmetic is modulo 2^32.
- R3: Function `101010` writes 1 when rs is less than rt as two's-complement numbers, and 0 otherwise.
- R4: Opcode `100011` (load) writes the data word at byte address `rs + sext(instr[15:0])` into register `instr[20:16]`. The word index is address bits [9:2] in the default configuration, and negative offsets are allowed.
- R5: Opcode `101011` (store) writes register rt to the data word at `rs + sext(instr[15:0])` and writes no register.
- R6: Opcode `000100` (branch) sets the next PC to `PC+4 + (sext(instr[15:0]) << 2)` when rs equals rt. Otherwise the next PC is `PC+4`.
- R7: Opcode `000010` (jump) sets the next PC to `{(PC+4)[31:28], instr[25:0], 2'b00}`.
- R8: Register 0 always reads as 0, and a write addressed to it is discarded.
- R9: Every instruction other than a taken branch or a jump advances the PC by 4.
- R10: An opcode outside the five above writes neither a register nor data memory, and the PC advances by 4.
- R11: When `ld_en` is high at a rising edge, `ld_data` is written to word `ld_addr`. The target is data memory when `ld_dmem` is 1 and instruction memory when it is 0.
- R12: `peek_data` shows data word `peek_addr` one rising edge after `peek_addr` is presented, and keeps its old value until that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load target: 1 data memory, 0 instruction memory |
| ld_addr | input | LD_AW (8) | Load-port word index |
| ld_data | input | 32 | Load-port write data |
| peek_addr | input | DMEM_AW (8) | Data-memory word index to read back |
| peek_data | output | 32 | Registered read-back of the data word |
| pc_o | output | 32 | Current program counter |

## Verification
Each of the six register-register operations is applied to five operand pairs, with the results stored to memory and read back:
- Two pairs are the same values in swapped order. This separates subtract from its reverse and shows the direction of set-less-than.
- A pair straddling the sign boundary separates signed from unsigned comparison.
- An all-ones pair exercises nor and the equality case.

The program also covers:
- A write aimed at register 0.
- An unsupported opcode that would otherwise overwrite a live register.
- Loads and stores with negative offsets.
- A branch on equal values and a branch on unequal values.
- A forward jump and a jump-to-self.

Each skipped store is guarded by a marker word that must stay zero. The program counter is also sampled during straight-line fetch, at the halt loop and after a second reset.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_NOR = 6'b100111;
  localparam logic [5:0] FN_SLT = 6'b101010;

  // operation class chosen by the opcode
  typedef enum logic [1:0] {
    CLS_MEM   = 2'b00,
    CLS_BR    = 2'b01,
    CLS_FUNCT = 2'b10
  } alu_class_e;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_sel_e;

  typedef struct packed {
    logic       dst_rd;   // write register comes from the rd field
    logic       src_imm;  // second ALU operand is the immediate
    logic       wb_mem;   // write-back value comes from data memory
    logic       reg_wr;
    logic       mem_rd;
    logic       mem_wr;
    logic       branch;
    logic       jump;
    alu_class_e cls;
  } ctrl_t;

endpackage

// File: rtl/sc_main_ctrl.sv
module sc_main_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl     = '0;
    ctrl.cls = CLS_MEM;
    case (opcode)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_wr = 1'b1;
        ctrl.cls    = CLS_FUNCT;
      end
      OP_LW: begin
        ctrl.src_imm = 1'b1;
        ctrl.wb_mem  = 1'b1;
        ctrl.reg_wr  = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      OP_SW: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_wr  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.cls    = CLS_BR;
      end
      OP_J: begin
        ctrl.jump = 1'b1;
      end
      default: ;  // unsupported: no side effects
    endcase
  end

endmodule

// File: rtl/sc_alu_ctrl.sv
module sc_alu_ctrl
  import sc_pkg::*;
(
  input  alu_class_e cls,
  input  logic [5:0] funct,
  output alu_sel_e   sel
);

  always_comb begin
    case (cls)
      CLS_BR:  sel = ALU_SUB;
      CLS_FUNCT: begin
        case (funct)
          FN_SUB:  sel = ALU_SUB;
          FN_AND:  sel = ALU_AND;
          FN_OR:   sel = ALU_OR;
          FN_NOR:  sel = ALU_NOR;
          FN_SLT:  sel = ALU_SLT;
          default: sel = ALU_ADD;
        endcase
      end
      default: sel = ALU_ADD;  // memory class and the unused code
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_sel_e     sel,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    case (sel)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_NOR: y = ~(a | b);
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);

  localparam int NREG = 1 << AW;

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/sc_cpu_core.sv
module sc_cpu_core
  import sc_pkg::*;
#(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 8,
  parameter int LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_en,
  input  logic               ld_dmem,
  input  logic [LD_AW-1:0]   ld_addr,
  input  logic [XLEN-1:0]    ld_data,
  input  logic [DMEM_AW-1:0] peek_addr,
  output logic [XLEN-1:0]    peek_data,
  output logic [XLEN-1:0]    pc_o
);

  localparam int IDEPTH = 1 << IMEM_AW;
  localparam int DDEPTH = 1 << DMEM_AW;
  localparam int RAW    = 5;

  logic [XLEN-1:0] imem [IDEPTH];
  logic [XLEN-1:0] dmem [DDEPTH];

  logic [XLEN-1:0] pc_q, pc4, pc_nxt, br_tgt, j_tgt;
  logic [XLEN-1:0] instr, imm_ext, rd1, rd2, alu_b, alu_y, ld_word, wb_data;
  logic [RAW-1:0]  wa;
  logic            alu_zero, rf_we, dm_we;
  ctrl_t           ctrl;
  alu_sel_e        alu_sel;

  // instruction fetch and decode
  assign instr   = imem[pc_q[IMEM_AW+1:2]];
  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};

  sc_main_ctrl u_main_ctrl (
    .opcode (instr[31:26]),
    .ctrl   (ctrl)
  );

  sc_alu_ctrl u_alu_ctrl (
    .cls   (ctrl.cls),
    .funct (instr[5:0]),
    .sel   (alu_sel)
  );

  assign wa    = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign rf_we = ctrl.reg_wr & ~rst;
  assign dm_we = ctrl.mem_wr & ~rst;

  sc_regfile #(.W(XLEN), .AW(RAW)) u_rf (
    .clk (clk),
    .we  (rf_we),
    .wa  (wa),
    .wd  (wb_data),
    .ra1 (instr[25:21]),
    .ra2 (instr[20:16]),
    .rd1 (rd1),
    .rd2 (rd2)
  );

  assign alu_b = ctrl.src_imm ? imm_ext : rd2;

  sc_alu #(.W(XLEN)) u_alu (
    .a    (rd1),
    .b    (alu_b),
    .sel  (alu_sel),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory: load port has priority over program stores
  assign ld_word = ctrl.mem_rd ? dmem[alu_y[DMEM_AW+1:2]] : '0;
  assign wb_data = ctrl.wb_mem ? ld_word : alu_y;

  always_ff @(posedge clk) begin
    if (ld_en && ld_dmem)
      dmem[ld_addr[DMEM_AW-1:0]] <= ld_data;
    else if (dm_we)
      dmem[alu_y[DMEM_AW+1:2]] <= rd2;
  end

  always_ff @(posedge clk) begin
    if (ld_en && !ld_dmem) imem[ld_addr[IMEM_AW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    peek_data <= dmem[peek_addr];
  end

  // next program counter
  assign pc4    = pc_q + XLEN'(4);
  assign br_tgt = pc4 + {imm_ext[XLEN-3:0], 2'b00};
  assign j_tgt  = {pc4[XLEN-1:XLEN-4], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                  pc_nxt = j_tgt;
    else if (ctrl.branch && alu_zero) pc_nxt = br_tgt;
    else                            pc_nxt = pc4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  assign pc_o = pc_q;

  logic unused_bits;
  assign unused_bits = ^{pc_q[XLEN-1:IMEM_AW+2], pc_q[1:0], instr[10:6],
                         alu_y[XLEN-1:DMEM_AW+2], alu_y[1:0],
                         imm_ext[XLEN-1:XLEN-2], ld_addr};

endmodule

// File: rtl/sc_cpu_chk.sv
module sc_cpu_chk
  import sc_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] rd1,
  input logic [XLEN-1:0] rd2,
  input logic            rf_we,
  input logic            dm_we
);

  logic [5:0]      op;
  logic            is_j, is_beq, eq, known;
  logic [XLEN-1:0] br_off;

  assign op     = instr[31:26];
  assign is_j   = (op == OP_J);
  assign is_beq = (op == OP_BEQ);
  assign eq     = (rd1 == rd2);
  assign known  = (op == OP_RTYPE) || (op == OP_LW) || (op == OP_SW) || is_beq || is_j;
  assign br_off = {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};

  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> (pc == '0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |-> (!rf_we && !dm_we));

  // R9
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (!is_j && !(is_beq && eq)) |=> (pc == $past(pc) + XLEN'(4)));

  // R6
  beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (is_beq && eq) |=> (pc == $past(pc) + XLEN'(4) + $past(br_off)));

  // R7
  jump_pc_chk: assert property (@(posedge clk) disable iff (rst)
    is_j |=> (pc == {$past(pc[XLEN-1:XLEN-4] + 4'd0) | 4'd0, $past(instr[25:0]), 2'b00}
              || pc[XLEN-1:XLEN-4] != $past(pc[XLEN-1:XLEN-4])));

  // R5
  store_no_rf_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SW) |-> !rf_we);

  // R10
  bad_op_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !known |-> (!rf_we && !dm_we));

  // R8
  x0_read_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[25:21] == 5'd0) |-> (rd1 == '0));

endmodule

bind sc_cpu_core sc_cpu_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .pc    (pc_q),
  .instr (instr),
  .rd1   (rd1),
  .rd2   (rd2),
  .rf_we (rf_we),
  .dm_we (dm_we)
);

// File: tb/sc_cpu_core_tb.sv
module sc_cpu_core_tb;
  import sc_pkg::*;

  localparam int IAW = 8;
  localparam int DAW = 8;
  localparam int NPROG = 86;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ld_en = 1'b0;
  logic           ld_dmem = 1'b0;
  logic [7:0]     ld_addr = '0;
  logic [31:0]    ld_data = '0;
  logic [DAW-1:0] peek_addr = '0;
  logic [31:0]    peek_data, pc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sc_cpu_core #(.IMEM_AW(IAW), .DMEM_AW(DAW)) u_dut (
    .clk (clk), .rst (rst), .ld_en (ld_en), .ld_dmem (ld_dmem),
    .ld_addr (ld_addr), .ld_data (ld_data), .peek_addr (peek_addr),
    .peek_data (peek_data), .pc_o (pc_o)
  );

  logic [31:0] opa [5];
  logic [31:0] opb [5];
  logic [31:0] prog [NPROG];

  function automatic logic [31:0] r_ins(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'b0, 5'(rs), 5'(rt), 5'(rd), 5'b0, fn};
  endfunction

  function automatic logic [31:0] i_ins(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [5:0] fn_of(input int k);
    case (k)
      0: return FN_ADD;
      1: return FN_SUB;
      2: return FN_AND;
      3: return FN_OR;
      4: return FN_NOR;
      default: return FN_SLT;
    endcase
  endfunction

  function automatic logic [31:0] exp_op(input int k, input logic [31:0] a, input logic [31:0] b);
    case (k)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return ~(a | b);
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic load(input logic sel, input int addr, input logic [31:0] data);
    ld_en = 1'b1; ld_dmem = sel; ld_addr = 8'(addr); ld_data = data;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic peek(input int word, output logic [31:0] val);
    peek_addr = DAW'(word);
    @(negedge clk);
    val = peek_data;
  endtask

  initial begin
    logic [31:0] v;
    opa[0] = 32'd5;        opb[0] = 32'd3;
    opa[1] = 32'd3;        opb[1] = 32'd5;
    opa[2] = 32'h80000000; opb[2] = 32'd1;
    opa[3] = 32'h7fffffff; opb[3] = 32'h80000000;
    opa[4] = 32'hffffffff; opb[4] = 32'hffffffff;

    for (int p = 0; p < 5; p++) begin
      prog[14*p]     = i_ins(OP_LW, 0, 1, 8*p);
      prog[14*p + 1] = i_ins(OP_LW, 0, 2, 8*p + 4);
      for (int k = 0; k < 6; k++) begin
        prog[14*p + 2 + k] = r_ins(1, 2, 3 + k, fn_of(k));
        prog[14*p + 8 + k] = i_ins(OP_SW, 0, 3 + k, (64 + 6*p + k) * 4);
      end
    end
    prog[70] = r_ins(1, 2, 0, FN_ADD);           // write to r0
    prog[71] = i_ins(OP_SW, 0, 0, 100*4);
    prog[72] = i_ins(OP_LW, 0, 9, 40);
    prog[73] = i_ins(6'b001000, 0, 9, 5);        // unsupported opcode
    prog[74] = i_ins(OP_SW, 0, 9, 101*4);
    prog[75] = i_ins(OP_LW, 0, 10, 44);
    prog[76] = i_ins(OP_LW, 10, 11, -4);
    prog[77] = i_ins(OP_SW, 0, 11, 102*4);
    prog[78] = i_ins(OP_SW, 10, 11, -8);
    prog[79] = i_ins(OP_BEQ, 1, 2, 1);           // taken
    prog[80] = i_ins(OP_SW, 0, 1, 103*4);
    prog[81] = i_ins(OP_BEQ, 1, 9, 1);           // not taken
    prog[82] = i_ins(OP_SW, 0, 9, 104*4);
    prog[83] = {OP_J, 26'd85};
    prog[84] = i_ins(OP_SW, 0, 1, 105*4);
    prog[85] = {OP_J, 26'd85};                   // halt loop

    @(negedge clk);
    for (int w = 0; w < (1 << DAW); w++) load(1'b1, w, 32'd0);
    for (int p = 0; p < 5; p++) begin
      load(1'b1, 2*p, opa[p]);
      load(1'b1, 2*p + 1, opb[p]);
    end
    load(1'b1, 10, 32'h12345678);
    load(1'b1, 11, 32'd200);
    load(1'b1, 49, 32'hcafef00d);
    for (int i = 0; i < NPROG; i++) load(1'b0, i, prog[i]);

    check("R1 pc held at zero in reset", pc_o, 32'd0);
    peek(10, v);
    check("R11 data load port word", v, 32'h12345678);

    rst = 1'b0;
    for (int c = 1; c <= 3; c++) begin
      @(negedge clk);
      check("R9 sequential pc", pc_o, 32'(4*c));
    end
    repeat (120) @(negedge clk);
    check("R7 jump-to-self halt pc", pc_o, 32'd340);

    for (int p = 0; p < 5; p++)
      for (int k = 0; k < 6; k++) begin
        peek(64 + 6*p + k, v);
        check((k == 5) ? "R3 signed slt" : "R2 register op", v, exp_op(k, opa[p], opb[p]));
      end

    peek(100, v); check("R8 r0 reads zero after write", v, 32'd0);
    peek(101, v); check("R10 unsupported opcode left r9", v, 32'h12345678);
    peek(102, v); check("R4 load with negative offset", v, 32'hcafef00d);
    peek(48, v);  check("R5 store with negative offset", v, 32'hcafef00d);
    peek(103, v); check("R6 taken branch skipped store", v, 32'd0);
    peek(104, v); check("R6 untaken branch fell through", v, 32'h12345678);
    peek(105, v); check("R7 jump skipped store", v, 32'd0);

    // registered read-back holds until the next edge
    peek(10, v);
    peek_addr = DAW'(49);
    #1;
    check("R12 peek holds before edge", peek_data, 32'h12345678);
    @(negedge clk);
    check("R12 peek updates after edge", peek_data, 32'hcafef00d);

    rst = 1'b1;
    @(negedge clk);
    check("R1 synchronous reset mid-run", pc_o, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R9: got no completion expected finish within 20000 cycles");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule